// File: doc/BRIEF.md
# Oversampling UART Receiver with IrDA Pulse Mode

This block turns an asynchronous serial line into received words. A programmable divider cuts the system clock down to a tick that runs at sixteen times the bit rate. The divider is selected by a 4-bit code. A two-flop synchronizer feeds a bit-cell state machine. In normal mode the machine votes over three centre samples of each cell. In IrDA mode it looks for a short low pulse inside each cell. A frame can carry 7 or 8 data bits and an optional extra ninth bit, which is stored exactly as it was received. The machine checks the stop bit, and completed words go into an eight-entry receive queue.

The queue can be switched to a single holding register. If a word arrives while the queue is full, the whole queue is emptied. A framing-error flag stays set until the next good frame arrives. While the shutdown input is high, reception stops, the queue and error flag are cleared, and any edge on the line sets an activity flag. The host removes the oldest word with a one-cycle pop strobe.

Top module: `uart_ovs_rx`

## Requirements
- R1: The tick period in system clocks is a ratio chosen by `div_code`. Codes 0-7 give 1, 2, 4, 8, 16, 32, 64 and 128. Codes 8-15 give 3, 6, 12, 24, 48, 96, 192 and 384. One bit lasts 16 ticks, and frames sent at 16 times the ratio clocks per bit are received correctly.
- R2: In normal mode a frame starts on a falling edge of the idle-high line. Each bit value is the majority of ticks 7, 8 and 9 of its cell, so a single-clock inversion at the cell centre has no effect on the word.
- R3: A start bit whose majority vote is high is a glitch. No word is stored, no error is flagged, and the receiver waits for a new falling edge.
- R4: Data is sent LSB first. `rd_word[7:0]` holds the data and `rd_word[8]` holds the extra bit. With `word7`=1 only 7 data bits are received and `rd_word[7]` reads 0. With `extra_en`=0 no extra bit is received and `rd_word[8]` reads 0.
- R5: A 0 sampled in the stop-bit cell sets `frame_err` and stores no word. `frame_err` stays set until the next correctly framed word is stored, and clears in that same cycle.
- R6: With `fifo_off`=0, up to 8 words are queued and read oldest first. `data_avail` is high while the queue is non-empty. `rd_word` is 0 when the queue is empty. A pop removes the oldest word.
- R7: A word that arrives while 8 words are queued and no pop is present empties the whole queue, and that incoming word is dropped too.
- R8: With `fifo_off`=1, a single holding register keeps only the newest word, and a pop empties it. Any change of `fifo_off` empties the stored words.
- R9: In IrDA mode (`irda_en`=1) the idle line is high and a 0 bit is a low pulse at the start of its cell. A cell reads 0 only if the line is low on two consecutive ticks. A low lasting a single tick is ignored, both in a 1 cell and while idle.
- R10: While `shutdown`=1, no word is received, the queue and `frame_err` are cleared, and any transition of the line sets `rx_activity`. `rx_activity` is 0 in the cycle after `shutdown` is low.
- R11: If a word completes in the same cycle as a pop on a non-empty queue, both take effect: the oldest word is removed and the new word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Tick divider selection code |
| word7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| extra_en | input | 1 | 1 adds an extra ninth bit after the data |
| irda_en | input | 1 | 1 selects IrDA pulse detection |
| fifo_off | input | 1 | 1 replaces the queue with one holding register |
| shutdown | input | 1 | Stops reception and enables activity detection |
| rx_in | input | 1 | Asynchronous serial line |
| pop | input | 1 | Removes the oldest stored word |
| rd_word | output | 9 | Oldest stored word, extra bit in bit 8 |
| data_avail | output | 1 | At least one word is stored |
| frame_err | output | 1 | The most recent frame had a bad stop bit |
| rx_activity | output | 1 | A line transition was seen during shutdown |

## Verification
The two functions that can fall in the same cycle are a completing frame pushing a word and a host pop removing one. The bench preloads two words and then sends a third frame. In separate trials it places a single pop at each of ten successive clocks around the centre of the stop bit, so one of those trials lands exactly on the push cycle. Every trial is judged by draining the queue: exactly the second and third words must come out, in that order, whatever the pop position.

// File: rtl/uor_pkg.sv
package uor_pkg;
  localparam int CODE_W = 4;
  localparam int DIVW   = 9;

  typedef enum logic [0:0] {ST_IDLE, ST_CELL} rx_state_e;

  // Ratio = (1 or 3) shifted left by the low three code bits
  function automatic logic [DIVW-1:0] div_ratio(input logic [CODE_W-1:0] code);
    logic [DIVW-1:0] base;
    base = code[CODE_W-1] ? DIVW'(3) : DIVW'(1);
    return base << code[2:0];
  endfunction
endpackage

// File: rtl/uor_tick_gen.sv
module uor_tick_gen
  import uor_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] lim;

  assign lim = div_ratio(code) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  // Checker: count clocks between ticks while the code is steady
  logic [DIVW-1:0]   gap_q;
  logic              seen_q;
  logic              chg_q;
  logic [CODE_W-1:0] code_d;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      chg_q  <= 1'b0;
      code_d <= code;
    end else begin
      code_d <= code;
      if (tick) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
        chg_q  <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
        chg_q <= chg_q | (code != code_d);
      end
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst || !run)
    (tick && seen_q && !chg_q && (code == code_d)) |-> (gap_q == lim));
endmodule

// File: rtl/uor_sampler.sv
module uor_sampler
  import uor_pkg::*;
#(
  parameter int MAXD = 8,
  parameter int OVS  = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_in,
  input  logic          irda_en,
  input  logic          word7,
  input  logic          extra_en,
  input  logic          halt,
  output logic          push,
  output logic [MAXD:0] word,
  output logic          frame_err,
  output logic          activity
);
  localparam int TW  = $clog2(OVS);
  localparam int BW  = $clog2(MAXD + 4);
  localparam int DW  = $clog2(MAXD);
  localparam int MID = OVS / 2;

  logic [1:0]      sync_q;
  logic            rx_s;
  logic            rx_prev;
  logic            halt_d;
  rx_state_e       state;
  logic            armed;
  logic            plow;
  logic            zseen;
  logic [TW-1:0]   tcnt;
  logic [BW-1:0]   bidx;
  logic            s7, s8;
  logic [MAXD-1:0] shreg;
  logic            ext;

  logic [BW-1:0]   ndata;
  logic [BW-1:0]   stop_idx;
  logic [DW-1:0]   dsel;
  logic            maj;
  logic            ir_hit;
  logic            bval;

  assign rx_s     = sync_q[1];
  assign ndata    = word7 ? BW'(MAXD - 1) : BW'(MAXD);
  assign stop_idx = BW'(1) + ndata + BW'(extra_en);
  assign dsel     = DW'(bidx - 1'b1);
  assign maj      = (s7 & s8) | (s7 & rx_s) | (s8 & rx_s);
  assign ir_hit   = !rx_s && plow;
  assign bval     = irda_en ? !(zseen | ir_hit) : maj;
  assign word     = {ext, shreg};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      rx_prev <= 1'b1;
      halt_d  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_in};
      rx_prev <= rx_s;
      halt_d  <= halt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) activity <= 1'b0;
    else     activity <= halt & ((halt_d & activity) | (rx_s != rx_prev));
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      plow      <= 1'b0;
      zseen     <= 1'b0;
      tcnt      <= '0;
      bidx      <= '0;
      s7        <= 1'b0;
      s8        <= 1'b0;
      shreg     <= '0;
      ext       <= 1'b0;
      push      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (rx_s) begin
              armed <= 1'b1;
              plow  <= 1'b0;
            end else if (armed) begin
              if (!irda_en) begin
                state <= ST_CELL;
                tcnt  <= TW'(1);
                bidx  <= '0;
                armed <= 1'b0;
                shreg <= '0;
                ext   <= 1'b0;
              end else if (plow) begin
                state <= ST_CELL;
                tcnt  <= TW'(2);
                bidx  <= '0;
                armed <= 1'b0;
                zseen <= 1'b1;
                shreg <= '0;
                ext   <= 1'b0;
              end else begin
                plow <= 1'b1;
              end
            end
          end
          default: begin
            tcnt <= (tcnt == TW'(OVS - 1)) ? '0 : tcnt + 1'b1;
            plow <= !rx_s;
            if (tcnt == TW'(OVS - 1)) begin
              zseen <= 1'b0;
              bidx  <= bidx + 1'b1;
            end else begin
              zseen <= zseen | ir_hit;
            end
            if (tcnt == TW'(MID - 2)) s7 <= rx_s;
            if (tcnt == TW'(MID - 1)) s8 <= rx_s;
            if (tcnt == TW'(MID)) begin
              if (bidx == '0) begin
                if (bval) state <= ST_IDLE;
              end else if (bidx == stop_idx) begin
                state <= ST_IDLE;
                if (bval) begin
                  push      <= 1'b1;
                  frame_err <= 1'b0;
                end else begin
                  frame_err <= 1'b1;
                end
              end else if (bidx <= ndata) begin
                shreg[dsel] <= bval;
              end else begin
                ext <= bval;
              end
            end
          end
        endcase
      end
    end
  end

  // R5
  fe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_err) |-> (push || $past(halt)));

  // R5
  fe_nopush_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> !push);

  // R10
  act_off_chk: assert property (@(posedge clk) disable iff (rst)
    !halt |=> !activity);

  // R3
  push_from_cell_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(state == ST_CELL));
endmodule

// File: rtl/uor_fifo.sv
module uor_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 9
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         bypass,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [W-1:0]  hold_q;
  logic          hold_v;
  logic          q_pop;
  logic          q_ovf;
  logic          q_we;

  assign q_pop = pop && (count != '0);
  assign q_ovf = push && !q_pop && (count == CW'(DEPTH));
  assign q_we  = push && !bypass && !flush && !q_ovf;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (q_we) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush || bypass) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (q_ovf) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)  wp <= nxt(wp);
      if (q_pop) rp <= nxt(rp);
      if (push && !q_pop)      count <= count + 1'b1;
      else if (!push && q_pop) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || !bypass) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (push) begin
      hold_q <= wdata;
      hold_v <= 1'b1;
    end else if (pop) begin
      hold_v <= 1'b0;
    end
  end

  always_comb begin
    if (bypass) begin
      avail = hold_v;
      rdata = hold_v ? hold_q : '0;
    end else begin
      avail = (count != '0);
      rdata = avail ? mem[rp] : '0;
    end
  end

  // R7
  ovf_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && !bypass && count == CW'(DEPTH)) |=> (count == '0));

  // R6
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && !bypass && count < CW'(DEPTH)) |=> (count == $past(count) + 1'b1));

  // R11
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !flush && !bypass && count != '0) |=> (count == $past(count)));

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
  import uor_pkg::*;
#(
  parameter int MAXD  = 8,
  parameter int OVS   = 16,
  parameter int DEPTH = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  input  logic              word7,
  input  logic              extra_en,
  input  logic              irda_en,
  input  logic              fifo_off,
  input  logic              shutdown,
  input  logic              rx_in,
  input  logic              pop,
  output logic [MAXD:0]     rd_word,
  output logic              data_avail,
  output logic              frame_err,
  output logic              rx_activity
);
  localparam int WW = MAXD + 1;

  logic          tick;
  logic          push;
  logic [WW-1:0] word;
  logic          mode_q;
  logic          flush;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_off;
  end

  assign flush = shutdown | (mode_q != fifo_off);

  uor_tick_gen u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (!shutdown),
    .code (div_code),
    .tick (tick)
  );

  uor_sampler #(.MAXD(MAXD), .OVS(OVS)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rx_in     (rx_in),
    .irda_en   (irda_en),
    .word7     (word7),
    .extra_en  (extra_en),
    .halt      (shutdown),
    .push      (push),
    .word      (word),
    .frame_err (frame_err),
    .activity  (rx_activity)
  );

  uor_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .bypass (fifo_off),
    .push   (push),
    .wdata  (word),
    .pop    (pop),
    .rdata  (rd_word),
    .avail  (data_avail)
  );
endmodule

// File: tb/uart_ovs_rx_tb_top.sv
module uart_ovs_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_code = 4'h0;
  logic       word7 = 1'b0;
  logic       extra_en = 1'b0;
  logic       irda_en = 1'b0;
  logic       fifo_off = 1'b0;
  logic       shutdown = 1'b0;
  logic       rx_in = 1'b1;
  logic       pop = 1'b0;
  logic [8:0] rd_word;
  logic       data_avail;
  logic       frame_err;
  logic       rx_activity;

  int checks = 0;
  int errs = 0;
  int dn;
  logic [8:0] dw [16];

  always #2.5 clk = ~clk;

  uart_ovs_rx dut_i (
    .clk(clk), .rst(rst), .div_code(div_code), .word7(word7),
    .extra_en(extra_en), .irda_en(irda_en), .fifo_off(fifo_off),
    .shutdown(shutdown), .rx_in(rx_in), .pop(pop), .rd_word(rd_word),
    .data_avail(data_avail), .frame_err(frame_err), .rx_activity(rx_activity)
  );

  typedef struct packed {
    logic [3:0] code;
    logic       w7;
    logic       pe;
    logic [7:0] d;
    logic       ex;
    logic [8:0] exp;
  } tv_t;

  localparam tv_t TV [8] = '{
    '{4'h0, 1'b0, 1'b0, 8'hA5, 1'b0, 9'h0A5},
    '{4'h0, 1'b1, 1'b0, 8'hC3, 1'b0, 9'h043},
    '{4'h0, 1'b0, 1'b1, 8'h3C, 1'b1, 9'h13C},
    '{4'h0, 1'b1, 1'b1, 8'h81, 1'b1, 9'h101},
    '{4'h1, 1'b0, 1'b0, 8'h5A, 1'b0, 9'h05A},
    '{4'h8, 1'b0, 1'b1, 8'h96, 1'b0, 9'h096},
    '{4'h9, 1'b0, 1'b1, 8'h0F, 1'b1, 9'h10F},
    '{4'h7, 1'b0, 1'b0, 8'hC6, 1'b0, 9'h0C6}
  };

  function automatic int tb_ratio(input logic [3:0] c);
    int b;
    b = c[3] ? 3 : 1;
    return b * (1 << c[2:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit w7, input bit pe, input bit ex,
                      input bit stop_v, input int cpb, input bit ir,
                      input int gb, input int gc, input int pop_at);
    logic bits [12];
    int nd, nb;
    logic ln;
    nd = w7 ? 7 : 8;
    bits[0] = 1'b0;
    for (int k = 0; k < nd; k++) bits[1+k] = d[k];
    nb = 1 + nd;
    if (pe) begin bits[nb] = ex; nb++; end
    bits[nb] = stop_v;
    nb++;
    for (int i = 0; i < nb * cpb; i++) begin
      int b, c;
      b = i / cpb;
      c = i % cpb;
      ln = ir ? (bits[b] | (c >= (3 * cpb) / 16)) : bits[b];
      if (b == gb && c == gc) ln = !ln;
      @(posedge clk); #1;
      rx_in = ln;
      pop = (i == pop_at);
    end
    @(posedge clk); #1;
    rx_in = 1'b1;
    pop = 1'b0;
    repeat (40) @(posedge clk);
  endtask

  task automatic drain();
    dn = 0;
    @(negedge clk);
    while (data_avail && dn < 16) begin
      dw[dn] = rd_word;
      dn++;
      @(posedge clk); #1 pop = 1'b1;
      @(posedge clk); #1 pop = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R6 reset data_avail", 32'(data_avail), 0);
    chk("R6 reset rd_word", 32'(rd_word), 0);
    chk("R5 reset frame_err", 32'(frame_err), 0);
    chk("R10 reset rx_activity", 32'(rx_activity), 0);

    // Vector table: divider codes and frame formats (R1, R4)
    for (int v = 0; v < 8; v++) begin
      div_code = TV[v].code;
      word7 = TV[v].w7;
      extra_en = TV[v].pe;
      repeat (5) @(posedge clk);
      send(TV[v].d, TV[v].w7, TV[v].pe, TV[v].ex, 1'b1, 16 * tb_ratio(TV[v].code), 1'b0, -1, -1, -1);
      @(negedge clk);
      chk($sformatf("R1 table avail v%0d", v), 32'(data_avail), 1);
      chk($sformatf("R4 table word v%0d", v), 32'(rd_word), 32'(TV[v].exp));
      drain();
    end
    div_code = 4'h0; word7 = 1'b0; extra_en = 1'b0;
    repeat (5) @(posedge clk);

    // R2: single-clock inversions at cell centres
    send(8'hA5, 0, 0, 0, 1, 16, 0, 3, 8, -1);
    send(8'h3C, 0, 0, 0, 1, 16, 0, 6, 9, -1);
    drain();
    chk("R2 majority count", 32'(dn), 2);
    chk("R2 majority word0", 32'(dw[0]), 32'h0A5);
    chk("R2 majority word1", 32'(dw[1]), 32'h03C);

    // R3: short start glitch
    @(posedge clk); #1 rx_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rx_in = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R3 glitch no word", 32'(data_avail), 0);
    chk("R3 glitch no error", 32'(frame_err), 0);
    send(8'h11, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R3 recovery word", 32'(rd_word), 32'h011);
    drain();

    // R5: bad stop bit then good frame
    send(8'h22, 0, 0, 0, 0, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R5 error set", 32'(frame_err), 1);
    chk("R5 no word", 32'(data_avail), 0);
    send(8'h33, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R5 error cleared", 32'(frame_err), 0);
    chk("R5 good word", 32'(rd_word), 32'h033);
    drain();

    // R6: order
    send(8'h01, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    send(8'h02, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    send(8'h03, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    drain();
    chk("R6 count", 32'(dn), 3);
    chk("R6 order0", 32'(dw[0]), 32'h001);
    chk("R6 order1", 32'(dw[1]), 32'h002);
    chk("R6 order2", 32'(dw[2]), 32'h003);
    @(negedge clk);
    chk("R6 empty word", 32'(rd_word), 0);

    // R7: overflow empties queue
    for (int k = 0; k < 8; k++) send(8'h40 + 8'(k), 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R7 full oldest", 32'(rd_word), 32'h040);
    send(8'h48, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R7 overflow avail", 32'(data_avail), 0);
    chk("R7 overflow word", 32'(rd_word), 0);

    // R11: pop swept across the push cycle
    for (int off = 0; off < 10; off++) begin
      drain();
      send(8'h61, 0, 0, 0, 1, 16, 0, -1, -1, -1);
      send(8'h62, 0, 0, 0, 1, 16, 0, -1, -1, -1);
      send(8'h63, 0, 0, 0, 1, 16, 0, -1, -1, 9 * 16 + 6 + off);
      drain();
      chk($sformatf("R11 count off%0d", off), 32'(dn), 2);
      chk($sformatf("R11 word0 off%0d", off), 32'(dw[0]), 32'h062);
      chk($sformatf("R11 word1 off%0d", off), 32'(dw[1]), 32'h063);
    end

    // R8: holding register
    fifo_off = 1'b1;
    repeat (4) @(posedge clk);
    send(8'h70, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    send(8'h71, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R8 newest kept", 32'(rd_word), 32'h071);
    chk("R8 avail", 32'(data_avail), 1);
    @(posedge clk); #1 pop = 1'b1;
    @(posedge clk); #1 pop = 1'b0;
    @(negedge clk);
    chk("R8 pop empties", 32'(data_avail), 0);
    send(8'h72, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    fifo_off = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 mode change flush", 32'(data_avail), 0);

    // R9: IrDA pulses
    irda_en = 1'b1;
    repeat (4) @(posedge clk);
    send(8'h4B, 0, 0, 0, 1, 16, 1, -1, -1, -1);
    @(negedge clk);
    chk("R9 irda word", 32'(rd_word), 32'h04B);
    drain();
    send(8'h5A, 0, 0, 0, 1, 16, 1, 2, 8, -1);
    @(negedge clk);
    chk("R9 short pulse in one cell", 32'(rd_word), 32'h05A);
    drain();
    @(posedge clk); #1 rx_in = 1'b0;
    @(posedge clk); #1 rx_in = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R9 idle short pulse", 32'(data_avail), 0);
    irda_en = 1'b0;
    repeat (4) @(posedge clk);

    // R10: shutdown
    send(8'h7E, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    shutdown = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 flush on entry", 32'(data_avail), 0);
    chk("R10 activity idle", 32'(rx_activity), 0);
    @(posedge clk); #1 rx_in = 1'b0;
    repeat (5) @(posedge clk);
    #1 rx_in = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 activity set", 32'(rx_activity), 1);
    send(8'h55, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R10 no reception", 32'(data_avail), 0);
    chk("R10 activity held", 32'(rx_activity), 1);
    @(posedge clk); #1 shutdown = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 activity cleared", 32'(rx_activity), 0);
    send(8'h3D, 0, 0, 0, 1, 16, 0, -1, -1, -1);
    @(negedge clk);
    chk("R10 resume word", 32'(rd_word), 32'h03D);

    finish_run();
  end
endmodule